// File: doc/BRIEF.md
# DMA Request Falling-Edge Arbiter

This block serves one DMA channel that works in single address mode and is driven by an active-low external request line. The line passes through a synchronizer. Its synchronized level is sampled on every clock edge while the channel is enabled. A low sample taken while acceptance is armed becomes a pending request, and that request is offered to the bus as `bus_req`. On the next cycle a small sequencer starts a single transfer: one read phase, then one write phase, with the acknowledge strobe `dack` held across both phases.

Acceptance is disarmed when a request is latched. It is armed again only after a high level has been sampled. If the high level is seen before the write phase ends, the block re-arms as that phase completes. If it is not, the block re-arms on the first high sample after the transfer. As a result, a line that is held low produces one transfer and no more, and each new falling edge produces exactly one further transfer.

Software starts the channel by pulsing `en_wr` with `en_val` high. The same pulse loads the transfer count. After the programmed number of transfers, the channel turns itself off and pulses `done`.

Top module: `dreq_edge_arbiter`

## Requirements
- R1: While reset is held and right after it, `bus_req`, `dack`, `cyc_active` and `done` are all low.
- R2: A cycle with `en_wr`=1 and `en_val`=1 loads `xfer_count`, arms request acceptance and raises `cyc_active` from the next cycle on. The request line reaches the sampling logic through `SYNC_STAGES` flops.
- R3: A low synchronized sample taken while the channel is enabled and armed raises `bus_req` for exactly one cycle. The transfer starts in the following cycle, and at that point the pending request is cleared.
- R4: Each transfer holds `dack` high for exactly two consecutive cycles (a read phase, then a write phase). `bus_req` stays low while `dack` is high and in the cycle after `dack` falls.
- R5: Holding the request line low produces only one transfer. A further transfer needs a high sample on the line after the request was latched.
- R6: If a high sample is seen during the transfer, acceptance re-arms as the write phase ends. If it is not, acceptance re-arms on the first later high sample. In either case the next low sample starts another transfer, so each falling edge yields exactly one transfer.
- R7: After the last programmed transfer, `cyc_active` drops and `done` is high for exactly one cycle, in the same cycle that `cyc_active` falls. Request activity after that point starts no transfer.
- R8: A cycle with `en_wr`=1 and `en_val`=0 drops any pending request, returns the logic to idle and clears `cyc_active` from the next cycle on. No transfer follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Write strobe for the channel enable bit |
| en_val | input | 1 | Enable value written by `en_wr` (1 start, 0 stop) |
| dreq_n | input | 1 | External request line, active low, asynchronous |
| xfer_count | input | CNT_W | Number of transfers, loaded when the channel is started |
| bus_req | output | 1 | Pending request offered to the bus |
| dack | output | 1 | Acknowledge strobe, high during both phases of a transfer |
| cyc_active | output | 1 | Channel enabled and not yet at terminal count |
| done | output | 1 | One-cycle pulse at terminal count |

## Verification
The bench builds the block with `CNT_W`=4 and `SYNC_STAGES`=2. The 4-bit count keeps terminal count within a few falling edges, so random trials with counts from 1 to 5 and from 0 to 7 edges regularly run below, at and past terminal count. The two-stage synchronizer gives a known latency. That lets the directed cases check the exact cycles of `bus_req` and `dack` after an enable write, and it lets a disable write land on the very edge where a request would otherwise be latched.

// File: rtl/dreq_arb_pkg.sv
package dreq_arb_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  // The line idles high, so every stage resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/dreq_gate.sv
module dreq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic start,
  input  logic stop,
  input  logic line_high,
  input  logic in_cycle,
  input  logic activate,
  input  logic write_end,
  output logic pending
);
  logic armed_q, armed_d;
  logic pend_q, pend_d;
  logic seen_q, seen_d;

  always_comb begin
    armed_d = armed_q;
    pend_d  = pend_q;
    seen_d  = seen_q;
    if (stop) begin
      armed_d = 1'b0;
      pend_d  = 1'b0;
      seen_d  = 1'b0;
    end else if (start) begin
      armed_d = 1'b1;
      pend_d  = 1'b0;
      seen_d  = 1'b0;
    end else if (chan_en) begin
      // Latch a request on a low sample and close the acceptance window.
      if (armed_q && !line_high && !pend_q && !in_cycle) begin
        pend_d  = 1'b1;
        armed_d = 1'b0;
        seen_d  = 1'b0;
      end
      if (activate) pend_d = 1'b0;
      // Look for the line going high while the request is being served.
      if ((pend_q || in_cycle) && line_high) seen_d = 1'b1;
      if (write_end) begin
        armed_d = seen_q || line_high;
        seen_d  = 1'b0;
      end else if (!armed_q && !pend_q && !in_cycle && line_high) begin
        armed_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pend_q  <= pend_d;
      seen_q  <= seen_d;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/dreq_seq.sv
module dreq_seq
  import dreq_arb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             start,
  input  logic             abort,
  input  logic             pending,
  input  logic [CNT_W-1:0] count_in,
  output logic             activate,
  output logic             in_cycle,
  output logic             write_end,
  output logic             term
);
  localparam logic [CNT_W-1:0] LAST = {{(CNT_W-1){1'b0}}, 1'b1};

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] rem_q, rem_d;

  assign activate  = chan_en && (st_q == SEQ_IDLE) && pending;
  assign in_cycle  = (st_q != SEQ_IDLE);
  assign write_end = (st_q == SEQ_WRITE);
  assign term      = write_end && (rem_q == LAST);

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    if (abort) begin
      st_d = SEQ_IDLE;
    end else begin
      case (st_q)
        SEQ_IDLE:  if (activate) st_d = SEQ_READ;
        SEQ_READ:  st_d = SEQ_WRITE;
        SEQ_WRITE: st_d = SEQ_IDLE;
        default:   st_d = SEQ_IDLE;
      endcase
    end
    if (start)          rem_d = count_in;
    else if (write_end) rem_d = rem_q - LAST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
    end
  end
endmodule

// File: rtl/dreq_edge_arbiter.sv
module dreq_edge_arbiter #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             en_val,
  input  logic             dreq_n,
  input  logic [CNT_W-1:0] xfer_count,
  output logic             bus_req,
  output logic             dack,
  output logic             cyc_active,
  output logic             done
);
  logic line_high, start, kill, stop;
  logic chan_en_q, chan_en_d, done_q;
  logic activate, in_cycle, write_end, term, pending;

  assign start = en_wr && en_val;
  assign kill  = en_wr && !en_val;
  assign stop  = kill || (term && !start);

  dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(dreq_n), .dout(line_high)
  );

  dreq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en_q), .start(start),
    .stop(stop), .line_high(line_high), .in_cycle(in_cycle),
    .activate(activate), .write_end(write_end), .pending(pending)
  );

  dreq_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en_q), .start(start),
    .abort(kill), .pending(pending), .count_in(xfer_count),
    .activate(activate), .in_cycle(in_cycle), .write_end(write_end),
    .term(term)
  );

  always_comb begin
    chan_en_d = chan_en_q;
    if (start)     chan_en_d = 1'b1;
    else if (stop) chan_en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      chan_en_q <= chan_en_d;
      done_q    <= term && !start && !kill;
    end
  end

  assign bus_req    = pending;
  assign dack       = in_cycle;
  assign cyc_active = chan_en_q;
  assign done       = done_q;
endmodule

module dreq_edge_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic en_wr,
  input logic en_val,
  input logic bus_req,
  input logic dack,
  input logic cyc_active,
  input logic done
);
  a_r3_req_starts_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !en_wr) |=> (dack && !bus_req));
  a_r4_dack_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dack) |=> dack);
  a_r4_dack_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (dack && $past(dack)) |=> !dack);
  a_r4_no_req_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> !bus_req);
  a_r4_no_req_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dack) |-> !bus_req);
  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cyc_active && !dack && !bus_req));
  a_r8_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !en_val) |=> (!bus_req && !cyc_active && !dack));
endmodule

bind dreq_edge_arbiter dreq_edge_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_val(en_val),
  .bus_req(bus_req), .dack(dack), .cyc_active(cyc_active), .done(done)
);

// File: tb/dreq_edge_arbiter_tb.sv
`timescale 1ns/1ps
module dreq_edge_arbiter_tb;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n, en_wr, en_val, dreq_n;
  logic [CW-1:0] xfer_count;
  logic bus_req, dack, cyc_active, done;

  int n_tests = 0, n_fail = 0;
  int n_xfer = 0, n_dack = 0, n_done = 0, n_breq = 0;
  logic dack_prev = 1'b0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dreq_edge_arbiter #(.CNT_W(CW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_val(en_val),
    .dreq_n(dreq_n), .xfer_count(xfer_count), .bus_req(bus_req),
    .dack(dack), .cyc_active(cyc_active), .done(done)
  );

  always @(negedge clk) begin
    if (dack && !dack_prev) n_xfer++;
    if (dack)    n_dack++;
    if (done)    n_done++;
    if (bus_req) n_breq++;
    dack_prev = dack;
  end

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr();
    n_xfer = 0; n_dack = 0; n_done = 0; n_breq = 0;
  endtask

  task automatic write_en(logic v, int cnt);
    en_wr = 1'b1; en_val = v; xfer_count = CW'(cnt);
    @(negedge clk);
    en_wr = 1'b0; en_val = 1'b0;
  endtask

  function automatic int exp_xfers(int edges, int cnt);
    return (edges < cnt) ? edges : cnt;
  endfunction

  initial begin
    rst_n = 1'b0; en_wr = 1'b0; en_val = 1'b0; dreq_n = 1'b1; xfer_count = '0;
    void'($urandom(32'd1234));
    cyc(3);
    check("R1 bus_req", bus_req, 0);
    check("R1 dack", dack, 0);
    check("R1 cyc_active", cyc_active, 0);
    check("R1 done", done, 0);
    rst_n = 1'b1;
    cyc(2);
    check("R1 after release", {bus_req, dack, cyc_active, done}, 0);

    // Line already low before the channel is started: exact timing.
    dreq_n = 1'b0;
    cyc(4);
    clr();
    write_en(1'b1, 3);
    check("R2 cyc_active", cyc_active, 1);
    check("R2 no early req", bus_req, 0);
    cyc(1);
    check("R3 bus_req", bus_req, 1);
    cyc(1);
    check("R3 dack start", dack, 1);
    check("R3 req cleared", bus_req, 0);
    cyc(1);
    check("R4 write phase", dack, 1);
    cyc(1);
    check("R4 dack end", dack, 0);
    cyc(25);
    check("R5 one xfer while low", n_xfer, 1);
    check("R4 dack cycles", n_dack, 2);

    dreq_n = 1'b1; cyc(5); dreq_n = 1'b0; cyc(12);
    check("R6 second edge", n_xfer, 2);
    // Short high pulse landing in the transfer window.
    dreq_n = 1'b1; cyc(6); dreq_n = 1'b0; cyc(3); dreq_n = 1'b1; cyc(2);
    dreq_n = 1'b0; cyc(15);
    check("R7 stops at count", n_xfer, 3);
    check("R7 done pulse", n_done, 1);
    check("R7 cyc_active low", cyc_active, 0);
    dreq_n = 1'b1; cyc(5); dreq_n = 1'b0; cyc(15);
    check("R7 ignored after tc", n_xfer, 3);

    // Disable written on the edge where a request would latch.
    dreq_n = 1'b0; cyc(4); clr();
    write_en(1'b1, 2);
    write_en(1'b0, 0);
    check("R8 cyc_active cleared", cyc_active, 0);
    cyc(20);
    check("R8 no transfer", n_xfer, 0);
    check("R8 no bus_req", n_breq, 0);
    dreq_n = 1'b1; cyc(6);

    // Random trials: falling edges with random level durations.
    for (int t = 0; t < 10; t++) begin
      int cnt, edges;
      cnt   = 1 + int'($urandom_range(4));
      edges = int'($urandom_range(7));
      dreq_n = 1'b1; cyc(6); clr();
      write_en(1'b1, cnt);
      cyc(int'($urandom_range(3)));
      for (int e = 0; e < edges; e++) begin
        dreq_n = 1'b0; cyc(4 + int'($urandom_range(8)));
        dreq_n = 1'b1; cyc(4 + int'($urandom_range(8)));
      end
      cyc(20);
      check("R6 random transfers", n_xfer, exp_xfers(edges, cnt));
      check("R4 random dack cycles", n_dack, 2 * exp_xfers(edges, cnt));
      check("R7 random done", n_done, (edges >= cnt) ? 1 : 0);
      check("R7 random active", cyc_active, (edges < cnt) ? 1 : 0);
      write_en(1'b0, 0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule